// File: doc/BRIEF.md
# Programmable Down-Counter / Square-Wave Timer with Ready Flag

This block is a 16-bit down-counter that works in one of two modes. It is meant for a peripheral's interrupt-status logic. In one-shot counting mode, a start command loads a preset value. The counter then counts down on each enabled cycle. When it reaches terminal count it raises a ready flag, and it holds there until the host issues another command. In periodic mode, the counter reloads the preset every time it reaches zero. It toggles a square-wave output at each reload and raises the ready flag once per full output period.

The host supplies the preset, a mode select and two single-cycle command strobes, start and stop. The mode select is captured when start is given. A count-enable input paces the countdown, so an external prescaler can run it at a divided rate. The stop command acts differently by mode. In counting mode it halts the counter and clears the flag. In periodic mode it only clears the flag, and the wave keeps running. The ready flag also appears as one bit of an interrupt-status word.

Top module: `ctr_timer_ready`

## Requirements
- R1: A synchronous active-low reset clears the count to 0, the ready flag to 0, the square-wave output to 0, and the whole status word to 0.
- R2: A start strobe loads the preset into the count on the next edge. It captures the mode select (0 = counting, 1 = periodic), clears the ready flag and drives the square wave to 0.
- R3: While the counter is running, each cycle with count enable high decrements the count by one. A cycle with count enable low leaves the count unchanged.
- R4: In counting mode, an enabled cycle that finds the count at 0 sets the ready flag at the next edge. The count then stays at 0 and counting stops, so a preset of N raises the flag after N+1 enabled cycles. The flag stays high until the next command.
- R5: In counting mode, a stop strobe clears the ready flag and halts the count at its present value. Further enabled cycles leave it unchanged.
- R6: In periodic mode, an enabled cycle that finds the count at 0 reloads the preset and inverts the square wave. Each half-period is therefore preset+1 enabled cycles long.
- R7: In periodic mode, the ready flag is set on every second reload after start. This is the reload that brings the square wave from 1 back to 0.
- R8: In periodic mode, a stop strobe clears the ready flag only. The count keeps decrementing and the square wave keeps toggling. If a flag-setting reload falls in the same cycle as the stop, the flag still ends up cleared.
- R9: When start and stop arrive in the same cycle, the count loads the preset and the flag is cleared. In counting mode the counter then stays halted. In periodic mode it runs.
- R10: In periodic mode with a preset of 0, the square wave inverts on every enabled cycle. The ready flag is set on every second enabled cycle.
- R11: The status word is 8 bits wide. The ready flag appears at bit 3 and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable, one countdown step per high cycle |
| mode_sel | input | 1 | 0 = counting, 1 = periodic; sampled with start |
| preset | input | 16 | Value loaded on start and on each periodic reload |
| start | input | 1 | Start command strobe |
| stop | input | 1 | Stop command strobe |
| count | output | 16 | Current count |
| ready | output | 1 | Ready flag, active high |
| sq_out | output | 1 | Square-wave level |
| irq_status | output | 8 | Status word carrying the ready flag at bit 3 |

## Verification
A wrong count value appears on the count output at the next edge. In periodic mode it shifts every later toggle of the square wave by the same number of enabled cycles. A corrupted phase bit shows up differently: the wave looks correct, but the ready flag rises on the wrong reload, which can be up to one half-period after the error. A wrong running bit freezes or unfreezes the count, and this is visible within one enabled cycle. Because the ready flag is sticky, an error in its set or clear terms persists until the next command and can be seen at any later sample.

// File: rtl/ctr_timer_pkg.sv
package ctr_timer_pkg;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_TIMER = 1'b1
    } ctr_mode_e;

    typedef struct packed {
        logic      load;      // reload count from preset
        logic      clr_flag;  // clear ready flag
        logic      halt;      // stop counting (counting mode only)
        ctr_mode_e eff_mode;  // mode that governs this cycle
    } ctr_ctl_t;

endpackage

// File: rtl/ctr_cmd_decode.sv
module ctr_cmd_decode
    import ctr_timer_pkg::*;
(
    input  logic      start,
    input  logic      stop,
    input  ctr_mode_e mode_in,
    input  ctr_mode_e mode_q,
    output ctr_ctl_t  ctl
);
    always_comb begin
        ctl.eff_mode = start ? mode_in : mode_q;
        ctl.load     = start;
        ctl.clr_flag = start | stop;
        ctl.halt     = stop & (ctl.eff_mode == MODE_COUNT);
    end
endmodule

// File: rtl/ctr_down_core.sv
module ctr_down_core #(
    parameter int W = 16
) (
    input  logic [W-1:0] count_q,
    input  logic [W-1:0] preset,
    input  logic         load,
    input  logic         step,
    input  logic         reload_on_tc,
    output logic [W-1:0] count_d,
    output logic         tc
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    always_comb begin
        tc      = step & (count_q == ZERO);
        count_d = count_q;
        if (load) begin
            count_d = preset;
        end else if (tc) begin
            count_d = reload_on_tc ? preset : ZERO;
        end else if (step) begin
            count_d = count_q - ONE;
        end
    end
endmodule

// File: rtl/ctr_wave_gen.sv
module ctr_wave_gen (
    input  logic load,
    input  logic tc,
    input  logic is_timer,
    input  logic sq_q,
    input  logic phase_q,
    output logic sq_d,
    output logic phase_d,
    output logic period_done
);
    logic wrap;

    always_comb begin
        wrap        = tc & is_timer;
        period_done = wrap & phase_q;
        sq_d        = sq_q;
        phase_d     = phase_q;
        if (load) begin
            sq_d    = 1'b0;
            phase_d = 1'b0;
        end else if (wrap) begin
            sq_d    = ~sq_q;
            phase_d = ~phase_q;
        end
    end
endmodule

// File: rtl/ctr_timer_ready.sv
module ctr_timer_ready
    import ctr_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int STAT_W  = 8,
    parameter int RDY_POS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              mode_sel,
    input  logic [CNT_W-1:0]  preset,
    input  logic              start,
    input  logic              stop,
    output logic [CNT_W-1:0]  count,
    output logic              ready,
    output logic              sq_out,
    output logic [STAT_W-1:0] irq_status
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
        logic             ready;
        logic             sq;
        logic             phase;
        ctr_mode_e        mode;
    } state_t;

    state_t   st_d, st_q;
    ctr_ctl_t ctl;
    ctr_mode_e mode_in;

    logic [CNT_W-1:0] core_count_d;
    logic             tc;
    logic             step;
    logic             sq_n, phase_n, period_done;
    logic             mode_lat, run_lat;

    assign mode_in = ctr_mode_e'(mode_sel);
    assign step    = cnt_en & st_q.running & ~start;

    ctr_cmd_decode u_cmd (
        .start   (start),
        .stop    (stop),
        .mode_in (mode_in),
        .mode_q  (st_q.mode),
        .ctl     (ctl)
    );

    ctr_down_core #(.W(CNT_W)) u_core (
        .count_q      (st_q.count),
        .preset       (preset),
        .load         (ctl.load),
        .step         (step),
        .reload_on_tc (st_q.mode == MODE_TIMER),
        .count_d      (core_count_d),
        .tc           (tc)
    );

    ctr_wave_gen u_wave (
        .load        (ctl.load),
        .tc          (tc),
        .is_timer    (st_q.mode == MODE_TIMER),
        .sq_q        (st_q.sq),
        .phase_q     (st_q.phase),
        .sq_d        (sq_n),
        .phase_d     (phase_n),
        .period_done (period_done)
    );

    always_comb begin
        logic flag_set;
        st_d       = st_q;
        st_d.count = core_count_d;
        st_d.sq    = sq_n;
        st_d.phase = phase_n;
        st_d.mode  = ctl.eff_mode;

        flag_set = (st_q.mode == MODE_COUNT) ? tc : period_done;

        if (ctl.load) begin
            st_d.running = ~ctl.halt;
        end else if (ctl.halt) begin
            st_d.running = 1'b0;
        end else if (tc && st_q.mode == MODE_COUNT) begin
            st_d.running = 1'b0;
        end

        if (ctl.clr_flag) begin
            st_d.ready = 1'b0;
        end else if (flag_set) begin
            st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{count: '0, running: 1'b0, ready: 1'b0,
                      sq: 1'b0, phase: 1'b0, mode: MODE_COUNT};
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.count;
    assign ready    = st_q.ready;
    assign sq_out   = st_q.sq;
    assign mode_lat = st_q.mode;
    assign run_lat  = st_q.running;

    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        if (b == RDY_POS) begin : g_rdy
            assign irq_status[b] = st_q.ready;
        end else begin : g_zero
            assign irq_status[b] = 1'b0;
        end
    end
endmodule

// File: rtl/ctr_timer_ready_chk.sv
module ctr_timer_ready_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             start,
    input logic             stop,
    input logic [CNT_W-1:0] preset,
    input logic [CNT_W-1:0] count,
    input logic             ready,
    input logic             sq_out,
    input logic             mode_lat,
    input logic             run_lat
);
    // R1
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !ready && !sq_out));

    // R2
    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == $past(preset) && !ready && !sq_out));

    // R5
    assert_halted_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_lat && !start) |=> $stable(count));

    // R6
    assert_timer_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lat && run_lat && cnt_en && !start && count == '0)
        |=> (sq_out != $past(sq_out) && count == $past(preset)));

    // R8
    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !ready);

    // R4
    assert_flag_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(count) == '0 && $past(cnt_en)));
endmodule

bind ctr_timer_ready ctr_timer_ready_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .start    (start),
    .stop     (stop),
    .preset   (preset),
    .count    (count),
    .ready    (ready),
    .sq_out   (sq_out),
    .mode_lat (mode_lat),
    .run_lat  (run_lat)
);

// File: tb/test_ctr_timer_ready.sv
module test_ctr_timer_ready;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        mode_sel = 1'b0;
    logic [15:0] preset = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [15:0] count;
    logic        ready;
    logic        sq_out;
    logic [7:0]  irq_status;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    always #2 clk = ~clk;

    ctr_timer_ready i_ctr_timer_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .mode_sel   (mode_sel),
        .preset     (preset),
        .start      (start),
        .stop       (stop),
        .count      (count),
        .ready      (ready),
        .sq_out     (sq_out),
        .irq_status (irq_status)
    );

    // fields: start stop mode en preset[16] exp_count[16] exp_rdy exp_sq
    localparam int NV = 15;
    localparam logic [37:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0,16'd3, 16'd3,1'b0,1'b0},  // R2 load
        {1'b0,1'b0,1'b0,1'b1,16'd3, 16'd2,1'b0,1'b0},  // R3
        {1'b0,1'b0,1'b0,1'b0,16'd3, 16'd2,1'b0,1'b0},  // R3 no enable
        {1'b0,1'b0,1'b0,1'b1,16'd3, 16'd1,1'b0,1'b0},
        {1'b0,1'b0,1'b0,1'b1,16'd3, 16'd0,1'b0,1'b0},
        {1'b0,1'b0,1'b0,1'b1,16'd3, 16'd0,1'b1,1'b0},  // R4 terminal
        {1'b0,1'b0,1'b0,1'b1,16'd3, 16'd0,1'b1,1'b0},  // R4 hold
        {1'b0,1'b1,1'b0,1'b0,16'd3, 16'd0,1'b0,1'b0},  // R5 clear
        {1'b1,1'b0,1'b1,1'b0,16'd1, 16'd1,1'b0,1'b0},  // R2 periodic
        {1'b0,1'b0,1'b1,1'b1,16'd1, 16'd0,1'b0,1'b0},
        {1'b0,1'b0,1'b1,1'b1,16'd1, 16'd1,1'b0,1'b1},  // R6 reload
        {1'b0,1'b0,1'b1,1'b1,16'd1, 16'd0,1'b0,1'b1},
        {1'b0,1'b0,1'b1,1'b1,16'd1, 16'd1,1'b1,1'b0},  // R7 flag
        {1'b0,1'b1,1'b1,1'b1,16'd1, 16'd0,1'b0,1'b0},  // R8 runs on
        {1'b0,1'b0,1'b1,1'b1,16'd1, 16'd1,1'b0,1'b1}   // R8 toggles
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic s, input logic p, input logic m,
                        input logic e, input logic [15:0] pv);
        start = s; stop = p; mode_sel = m; cnt_en = e; preset = pv;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; stop = 1'b0; cnt_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 200000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc_cnt, 200000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 ready", ready, 0);
        chk("R1 sq", sq_out, 0);
        chk("R1 status", irq_status, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            tick(VEC[i][37], VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:18]);
            chk("vec count", count, VEC[i][17:2]);
            chk("vec ready", ready, VEC[i][1]);
            chk("vec sq", sq_out, VEC[i][0]);
        end

        // R5 stop mid-count halts
        tick(1, 0, 0, 0, 16'd5);
        tick(0, 0, 0, 1, 16'd5);
        tick(0, 0, 0, 1, 16'd5);
        tick(0, 1, 0, 0, 16'd5);
        chk("R5 halted value", count, 3);
        tick(0, 0, 0, 1, 16'd5);
        tick(0, 0, 0, 1, 16'd5);
        chk("R5 stays halted", count, 3);
        chk("R5 flag low", ready, 0);

        // R9 start+stop, counting mode: loaded and halted
        tick(1, 1, 0, 1, 16'd4);
        chk("R9 counting load", count, 4);
        tick(0, 0, 0, 1, 16'd4);
        chk("R9 counting halted", count, 4);

        // R9 start+stop, periodic mode: loaded and running
        tick(1, 1, 1, 1, 16'd2);
        chk("R9 periodic load", count, 2);
        chk("R9 periodic flag", ready, 0);
        tick(0, 0, 1, 1, 16'd2);
        chk("R9 periodic runs", count, 1);

        // R10 preset zero periodic
        tick(1, 0, 1, 0, 16'd0);
        tick(0, 0, 1, 1, 16'd0);
        chk("R10 sq first", sq_out, 1);
        chk("R10 flag first", ready, 0);
        tick(0, 0, 1, 1, 16'd0);
        chk("R10 sq second", sq_out, 0);
        chk("R10 flag second", ready, 1);
        // R11 status word bit 3
        chk("R11 status", irq_status, 8);
        tick(0, 0, 1, 0, 16'd0);
        chk("R10 no enable hold", sq_out, 0);

        // R6 half-period length with preset 2 = 3 enables
        tick(1, 0, 1, 0, 16'd2);
        begin
            int n = 0;
            while (sq_out == 1'b0 && n < 20) begin
                tick(0, 0, 1, 1, 16'd2);
                n++;
            end
            chk("R6 half period", n, 3);
        end

        // R8 stop coinciding with the flag-setting reload
        tick(1, 0, 1, 0, 16'd0);
        tick(0, 0, 1, 1, 16'd0);
        tick(0, 1, 1, 1, 16'd0);
        chk("R8 stop wins flag", ready, 0);
        chk("R8 sq still toggles", sq_out, 0);

        // R4 long count: preset 1000 needs 1001 enables
        tick(1, 0, 0, 0, 16'd1000);
        begin
            int n = 0;
            while (!ready && n < 2000) begin
                tick(0, 0, 0, 1, 16'd1000);
                n++;
            end
            chk("R4 enables to flag", n, 1001);
        end
        chk("R11 status set", irq_status, 8);

        // R1 mid-run reset
        tick(1, 0, 1, 0, 16'd7);
        tick(0, 0, 1, 1, 16'd7);
        rst_n = 1'b0;
        tick(0, 0, 0, 0, 16'd7);
        chk("R1 reset count", count, 0);
        chk("R1 reset sq", sq_out, 0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule